// File: doc/BRIEF.md
# Byte-Stream Command Register Decoder

This block sits behind a serial byte receiver. It turns framed command packets into updates of a small control register file and a byte table. A packet opens with a start strobe, carries its bytes over a valid/ready stream, and closes with an end strobe. The first byte is an opcode and the bytes after it are arguments. The whole packet is buffered first. Once the end strobe arrives and the length is legal, the packet runs one step per clock. The byte stream is held off with `in_ready_o` low until the last step is done.

Neighbouring timer and PWM blocks read their settings from dedicated register outputs. They are told to act through one-cycle pulses: note-on, note-off and PWM update. Single-byte reads are requested on a valid/ready request port and are answered one cycle later. Each read comes from the register file or the table, as chosen by a source register, at that source's own auto-incrementing pointer. Write packets are steered the same way, using a destination register and per-destination write pointers. A bad source or destination never stalls the block. It sets a sticky bit in the error register instead.

Top module: `cmd_regdec`

## Requirements
- R1: A packet is the bytes accepted between `pkt_sop_i` and `pkt_eop_i`. A byte accepted in the same cycle as `pkt_eop_i` belongs to the packet. A packet of zero bytes is discarded, and so is a packet of more than 17 bytes (more than 16 arguments). A packet of exactly 17 bytes is executed. Arguments beyond the number an opcode uses are ignored.
- R2: Back-pressure works as follows. `in_ready_o` and `rd_req_ready_o` are low from the clock after a legal end strobe until the packet has finished executing. While `in_ready_o` is low, no byte is taken and start strobes are ignored.
- R3: Opcode 0 copies up to three arguments into registers 11 (duty), 12 (period) and 13 (divider), in that order. When it finishes, it raises `pwm_update_o` for one cycle.
- R4: Opcode 2 copies up to three arguments into registers 8 (coarse), 9 (fine) and 10 (prescale). If register 8 is then above register 16, register 8 becomes the value of register 16 and error bit 0x04 is set. A single `note_on_o` pulse follows. Opcode 1 pulses `note_on_o` only. Opcode 3 pulses `note_off_o` only. At most one of the three pulses is high in any cycle.
- R5: Opcode 4 writes its first argument into register 3 (read source). A second argument, if present, is written into the register whose index is that first argument (0 = register pointer, 1 = table pointer).
- R6: A read request accepted with source 0 returns, on the next cycle, the register at the pointer in register 0. A request with source 1 returns the table byte at the pointer in register 1. In both cases the pointer used is then incremented. Any other source sets error bit 0x01, and `rd_valid_o` stays low.
- R7: In opcode 5, bits 2:0 of the first argument select the destination: 4 = register file, 5 = table, 6 = no storage. This value is stored in register 7. If bit 3 is set, the second argument loads the chosen destination's pointer register (register 4, 5 or 6). Each later byte is written at the destination's pointer, and the pointer is then incremented. When the data byte lands on the pointer register itself, the data byte wins.
- R8: A destination outside 4 to 6 sets error bit 0x02, and the rest of that packet is skipped. Destination 6 advances register 6 but stores nothing. Opcode 6 changes nothing.
- R9: Error bits gather by OR in register 15, which is also driven on `err_o`. Only an explicit register write can clear them.
- R10: After reset, the registers hold: 8 = 5, 9 = 0, 10 = 4, 11 = 127, 12 = 255, 13 = 5, 16 = 14, 17 = 0, 18 = 250, 19 = 0, 7 = 4. All other registers hold 0.
- R11: Opcode 7 copies up to two arguments into registers 17 and 18. Opcode 8 copies its first argument into register 19.
- R12: Opcodes 9 and above change no register and emit no pulse.
- R13: A register pointer at or above 20 reads as 0 and drops writes, but the pointer still increments (8-bit wrap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_sop_i | input | 1 | Start-of-packet strobe |
| pkt_eop_i | input | 1 | End-of-packet strobe |
| in_valid_i | input | 1 | Packet byte valid |
| in_data_i | input | 8 | Packet byte |
| in_ready_o | output | 1 | Byte stream ready (low while executing) |
| rd_req_valid_i | input | 1 | Single-byte read request |
| rd_req_ready_o | output | 1 | Read request can be accepted |
| rd_valid_o | output | 1 | Read response valid, one cycle after acceptance |
| rd_data_o | output | 8 | Read response byte |
| pwm_update_o | output | 1 | PWM settings changed pulse |
| note_on_o | output | 1 | Note-on pulse |
| note_off_o | output | 1 | Note-off pulse |
| atk_coarse_o | output | 8 | Register 8 |
| atk_fine_o | output | 8 | Register 9 |
| atk_prescale_o | output | 8 | Register 10 |
| pwm_duty_o | output | 8 | Register 11 |
| pwm_period_o | output | 8 | Register 12 |
| pwm_div_o | output | 8 | Register 13 |
| hold_coarse_o | output | 8 | Register 17 |
| hold_fine_o | output | 8 | Register 18 |
| flags_o | output | 8 | Register 19 |
| err_o | output | 8 | Register 15, sticky error bits |

## Verification
The decoder is fed packets of several kinds:
- Full and partial argument lists, which show whether each opcode stops at its own argument count.
- An over-range coarse value, which separates the clamped path from the plain copy path.
- Write packets with and without the address flag, to each destination and to an illegal one. These show pointer loading apart from pointer continuation, and table storage apart from register storage.
- Packets of length zero, sixteen arguments and seventeen arguments, which bracket the discard rule.

Reads walk both sources and an illegal source, proving that pointers advance and that errors stick.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  localparam int REG_COUNT = 20;

  // register indices
  localparam int IX_RD_REG  = 0;
  localparam int IX_RD_TAB  = 1;
  localparam int IX_RD_NV   = 2;
  localparam int IX_RD_SRC  = 3;
  localparam int IX_WR_REG  = 4;
  localparam int IX_WR_TAB  = 5;
  localparam int IX_WR_NV   = 6;
  localparam int IX_WR_DST  = 7;
  localparam int IX_COARSE  = 8;
  localparam int IX_FINE    = 9;
  localparam int IX_PRESC   = 10;
  localparam int IX_DUTY    = 11;
  localparam int IX_PERIOD  = 12;
  localparam int IX_DIV     = 13;
  localparam int IX_STATE   = 14;
  localparam int IX_ERR     = 15;
  localparam int IX_MAXC    = 16;
  localparam int IX_HCOARSE = 17;
  localparam int IX_HFINE   = 18;
  localparam int IX_FLAGS   = 19;

  // opcodes
  localparam logic [7:0] OP_PWM    = 8'd0;
  localparam logic [7:0] OP_NOTE_V = 8'd1;
  localparam logic [7:0] OP_NOTE_T = 8'd2;
  localparam logic [7:0] OP_OFF    = 8'd3;
  localparam logic [7:0] OP_RDADDR = 8'd4;
  localparam logic [7:0] OP_WRITE  = 8'd5;
  localparam logic [7:0] OP_STORE  = 8'd6;
  localparam logic [7:0] OP_HOLD   = 8'd7;
  localparam logic [7:0] OP_FLAGS  = 8'd8;

  // sticky error bits
  localparam logic [7:0] ERR_RDSRC = 8'h01;
  localparam logic [7:0] ERR_WRDST = 8'h02;
  localparam logic [7:0] ERR_CLAMP = 8'h04;

  typedef enum logic {ST_IDLE, ST_RUN} exec_state_t;

  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    case (idx)
      IX_WR_DST: v = 8'd4;
      IX_COARSE: v = 8'd5;
      IX_PRESC:  v = 8'd4;
      IX_DUTY:   v = 8'd127;
      IX_PERIOD: v = 8'd255;
      IX_DIV:    v = 8'd5;
      IX_MAXC:   v = 8'd14;
      IX_HFINE:  v = 8'd250;
      default:   v = 8'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cmd_regdec_collect.sv
module cmd_regdec_collect #(
  parameter int MAX_ARGS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic valid_i,
  input  logic [7:0] data_i,
  output logic ready_o,
  output logic go_o,
  output logic [$clog2(MAX_ARGS+2)-1:0] nbytes_o,
  output logic [MAX_ARGS:0][7:0] bytes_o
);
  localparam int DEPTH = MAX_ARGS + 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, base_cnt, cnt_nx;
  logic ovf_q, base_ovf, ovf_nx;
  logic accept, store;
  logic [DEPTH-1:0][7:0] bytes_q;

  assign ready_o = !busy_i;
  assign accept  = valid_i && !busy_i;

  always_comb begin
    base_cnt = (sop_i && !busy_i) ? '0 : cnt_q;
    base_ovf = (sop_i && !busy_i) ? 1'b0 : ovf_q;
    cnt_nx   = base_cnt;
    ovf_nx   = base_ovf;
    store    = 1'b0;
    if (accept) begin
      if (base_cnt == CW'(DEPTH)) begin
        ovf_nx = 1'b1;
      end else begin
        store  = 1'b1;
        cnt_nx = base_cnt + 1'b1;
      end
    end
  end

  assign go_o     = eop_i && !busy_i && !ovf_nx && (cnt_nx != '0);
  assign nbytes_o = cnt_nx;
  assign bytes_o  = bytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      bytes_q <= '0;
    end else begin
      if (store) bytes_q[base_cnt] <= data_i;
      if (eop_i && !busy_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        ovf_q <= ovf_nx;
      end
    end
  end
endmodule

// File: rtl/cmd_regdec_regs.sv
module cmd_regdec_regs
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = REG_COUNT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_en,
  input  logic [7:0] a_idx,
  input  logic [7:0] a_dat,
  input  logic b_en,
  input  logic [7:0] b_idx,
  input  logic [7:0] b_dat,
  output logic [NUM_REGS-1:0][7:0] regs_o
);
  // port A (data) wins over port B (pointer / error update) on the same entry
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[gi] <= reg_default(gi);
      end else if (a_en && a_idx == 8'(gi)) begin
        regs_o[gi] <= a_dat;
      end else if (b_en && b_idx == 8'(gi)) begin
        regs_o[gi] <= b_dat;
      end
    end
  end
endmodule

// File: rtl/cmd_regdec_table.sv
module cmd_regdec_table #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0] wdata,
  input  logic re,
  input  logic [AW-1:0] raddr,
  output logic [7:0] rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmd_regdec.sv
module cmd_regdec
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS    = REG_COUNT,
  parameter int TABLE_DEPTH = 256,
  parameter int MAX_ARGS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_sop_i,
  input  logic       pkt_eop_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  input  logic       rd_req_valid_i,
  output logic       rd_req_ready_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       pwm_update_o,
  output logic       note_on_o,
  output logic       note_off_o,
  output logic [7:0] atk_coarse_o,
  output logic [7:0] atk_fine_o,
  output logic [7:0] atk_prescale_o,
  output logic [7:0] pwm_duty_o,
  output logic [7:0] pwm_period_o,
  output logic [7:0] pwm_div_o,
  output logic [7:0] hold_coarse_o,
  output logic [7:0] hold_fine_o,
  output logic [7:0] flags_o,
  output logic [7:0] err_o
);
  localparam int DEPTH = MAX_ARGS + 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TAW   = $clog2(TABLE_DEPTH);

  exec_state_t state_q;
  logic busy, go;
  logic [CW-1:0] nbytes, nargs_q, step_q, last;
  logic [DEPTH-1:0][7:0] pkt;
  logic [NUM_REGS-1:0][7:0] regs;
  logic a_en, b_en;
  logic [7:0] a_idx, a_dat, b_idx, b_dat;
  logic tab_we, tab_re;
  logic [TAW-1:0] tab_waddr;
  logic [7:0] tab_wdata, tab_rdata;
  logic abort_q, abort_set, fin;
  logic pwm_p, on_p, off_p, rd_fire, rd_tab;
  logic rd_valid_q, rd_tab_q;
  logic [7:0] rd_reg_q;
  logic [7:0] op, arg, arg0, dsel, ptr, err;

  assign busy = (state_q == ST_RUN);

  cmd_regdec_collect #(.MAX_ARGS(MAX_ARGS)) u_collect (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .sop_i(pkt_sop_i), .eop_i(pkt_eop_i),
    .valid_i(in_valid_i), .data_i(in_data_i), .ready_o(in_ready_o),
    .go_o(go), .nbytes_o(nbytes), .bytes_o(pkt)
  );

  cmd_regdec_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_idx(a_idx), .a_dat(a_dat),
    .b_en(b_en), .b_idx(b_idx), .b_dat(b_dat), .regs_o(regs)
  );

  cmd_regdec_table #(.DEPTH(TABLE_DEPTH), .AW(TAW)) u_table (
    .clk(clk), .we(tab_we), .waddr(tab_waddr), .wdata(tab_wdata),
    .re(tab_re), .raddr(regs[IX_RD_TAB][TAW-1:0]), .rdata(tab_rdata)
  );

  // register lookup by byte index; indices past the file read as zero
  function automatic logic [7:0] rget(input logic [7:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) if (idx == 8'(i)) r = regs[i];
    return r;
  endfunction

  function automatic logic [CW-1:0] lim(input logic [CW-1:0] n, input int m);
    return (n < CW'(m)) ? n : CW'(m);
  endfunction

  assign op   = pkt[0];
  assign arg0 = pkt[1];
  assign err  = regs[IX_ERR];
  assign dsel = regs[IX_WR_DST];
  assign ptr  = rget(dsel);

  always_comb begin
    arg = 8'h00;
    for (int j = 0; j < MAX_ARGS; j++) if (step_q == CW'(j)) arg = pkt[j+1];
  end

  // index of the finishing step for the packet in flight
  always_comb begin
    case (op)
      OP_PWM, OP_NOTE_T:  last = lim(nargs_q, 3);
      OP_HOLD, OP_RDADDR: last = lim(nargs_q, 2);
      OP_FLAGS:           last = lim(nargs_q, 1);
      OP_WRITE:           last = nargs_q;
      default:            last = '0;
    endcase
  end

  assign fin = (step_q == last);

  always_comb begin
    a_en = 1'b0; a_idx = '0; a_dat = '0;
    b_en = 1'b0; b_idx = '0; b_dat = '0;
    tab_we = 1'b0; tab_waddr = ptr[TAW-1:0]; tab_wdata = arg;
    tab_re = 1'b0;
    abort_set = 1'b0;
    pwm_p = 1'b0; on_p = 1'b0; off_p = 1'b0;
    rd_fire = 1'b0; rd_tab = 1'b0;
    if (busy) begin
      case (op)
        OP_PWM: begin
          if (!fin) begin a_en = 1'b1; a_idx = 8'(IX_DUTY) + 8'(step_q); a_dat = arg; end
          else pwm_p = 1'b1;
        end
        OP_NOTE_T: begin
          if (!fin) begin
            a_en = 1'b1; a_idx = 8'(IX_COARSE) + 8'(step_q); a_dat = arg;
          end else begin
            on_p = 1'b1;
            if (regs[IX_COARSE] > regs[IX_MAXC]) begin
              a_en = 1'b1; a_idx = 8'(IX_COARSE); a_dat = regs[IX_MAXC];
              b_en = 1'b1; b_idx = 8'(IX_ERR);    b_dat = err | ERR_CLAMP;
            end
          end
        end
        OP_NOTE_V: on_p  = 1'b1;
        OP_OFF:    off_p = 1'b1;
        OP_HOLD: begin
          if (!fin) begin a_en = 1'b1; a_idx = 8'(IX_HCOARSE) + 8'(step_q); a_dat = arg; end
        end
        OP_FLAGS: begin
          if (!fin) begin a_en = 1'b1; a_idx = 8'(IX_FLAGS); a_dat = arg; end
        end
        OP_RDADDR: begin
          if (!fin) begin
            a_en  = 1'b1;
            a_dat = arg;
            a_idx = (step_q == '0) ? 8'(IX_RD_SRC) : arg0;
          end
        end
        OP_WRITE: begin
          if (!fin && !abort_q) begin
            if (step_q == '0) begin
              if (arg[2:0] < 3'd4 || arg[2:0] > 3'd6) begin
                b_en = 1'b1; b_idx = 8'(IX_ERR); b_dat = err | ERR_WRDST;
                abort_set = 1'b1;
              end else begin
                a_en = 1'b1; a_idx = 8'(IX_WR_DST); a_dat = {5'b0, arg[2:0]};
              end
            end else if (step_q == CW'(1) && arg0[3]) begin
              a_en = 1'b1; a_idx = {5'b0, arg0[2:0]}; a_dat = arg;
            end else begin
              case (dsel)
                8'(IX_WR_REG): begin
                  a_en = 1'b1; a_idx = ptr; a_dat = arg;
                  b_en = 1'b1; b_idx = dsel; b_dat = ptr + 8'd1;
                end
                8'(IX_WR_TAB): begin
                  tab_we = 1'b1;
                  b_en = 1'b1; b_idx = dsel; b_dat = ptr + 8'd1;
                end
                8'(IX_WR_NV): begin
                  b_en = 1'b1; b_idx = dsel; b_dat = ptr + 8'd1;
                end
                default: begin
                  b_en = 1'b1; b_idx = 8'(IX_ERR); b_dat = err | ERR_WRDST;
                end
              endcase
            end
          end
        end
        default: ;
      endcase
    end else if (rd_req_valid_i) begin
      case (regs[IX_RD_SRC])
        8'(IX_RD_REG): begin
          rd_fire = 1'b1;
          b_en = 1'b1; b_idx = 8'(IX_RD_REG); b_dat = regs[IX_RD_REG] + 8'd1;
        end
        8'(IX_RD_TAB): begin
          rd_fire = 1'b1; rd_tab = 1'b1; tab_re = 1'b1;
          b_en = 1'b1; b_idx = 8'(IX_RD_TAB); b_dat = regs[IX_RD_TAB] + 8'd1;
        end
        default: begin
          b_en = 1'b1; b_idx = 8'(IX_ERR); b_dat = err | ERR_RDSRC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      nargs_q      <= '0;
      step_q       <= '0;
      abort_q      <= 1'b0;
      pwm_update_o <= 1'b0;
      note_on_o    <= 1'b0;
      note_off_o   <= 1'b0;
      rd_valid_q   <= 1'b0;
      rd_tab_q     <= 1'b0;
      rd_reg_q     <= '0;
    end else begin
      pwm_update_o <= pwm_p;
      note_on_o    <= on_p;
      note_off_o   <= off_p;
      rd_valid_q   <= rd_fire;
      if (rd_fire) begin
        rd_tab_q <= rd_tab;
        rd_reg_q <= rget(regs[IX_RD_REG]);
      end
      if (!busy) begin
        if (go) begin
          state_q <= ST_RUN;
          nargs_q <= nbytes - 1'b1;
          step_q  <= '0;
          abort_q <= 1'b0;
        end
      end else begin
        if (abort_set) abort_q <= 1'b1;
        if (fin) state_q <= ST_IDLE;
        else     step_q  <= step_q + 1'b1;
      end
    end
  end

  assign rd_req_ready_o = !busy;
  assign rd_valid_o     = rd_valid_q;
  assign rd_data_o      = rd_tab_q ? tab_rdata : rd_reg_q;

  assign atk_coarse_o   = regs[IX_COARSE];
  assign atk_fine_o     = regs[IX_FINE];
  assign atk_prescale_o = regs[IX_PRESC];
  assign pwm_duty_o     = regs[IX_DUTY];
  assign pwm_period_o   = regs[IX_PERIOD];
  assign pwm_div_o      = regs[IX_DIV];
  assign hold_coarse_o  = regs[IX_HCOARSE];
  assign hold_fine_o    = regs[IX_HFINE];
  assign flags_o        = regs[IX_FLAGS];
  assign err_o          = err;
endmodule

// File: rtl/cmd_regdec_chk.sv
module cmd_regdec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_req_valid,
  input logic       rd_req_ready,
  input logic       rd_valid,
  input logic       note_on,
  input logic       note_off,
  input logic       pwm_update,
  input logic [7:0] err
);
  // R4: the three event pulses never overlap
  assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({note_on, note_off, pwm_update}));

  // R2 / R4: event pulses only come out of packet execution
  assert_pulse_from_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (note_on || note_off || pwm_update) |-> $past(busy));

  // R6: a response follows an accepted request
  assert_resp_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req_valid && rd_req_ready));

  // R2: a refused request gets no response
  assert_refused_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> !rd_valid);

  // R9: outside packet execution, error bits can only be added
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ((err & $past(err)) == $past(err)));
endmodule

bind cmd_regdec cmd_regdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .rd_req_valid(rd_req_valid_i), .rd_req_ready(rd_req_ready_o), .rd_valid(rd_valid_o),
  .note_on(note_on_o), .note_off(note_off_o), .pwm_update(pwm_update_o), .err(err_o)
);

// File: tb/cmd_regdec_tb.sv
module cmd_regdec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop = 0, eop = 0, in_valid = 0, rd_req = 0;
  logic [7:0] in_data = 0;
  logic in_ready, rd_ready, rd_valid, pwm_up, n_on, n_off;
  logic [7:0] rd_data, c_coarse, c_fine, c_presc, c_duty, c_period, c_div, c_hc, c_hf, c_flags, c_err;

  int checks = 0, fails = 0;
  int cnt_pwm = 0, cnt_on = 0, cnt_off = 0;
  logic [7:0] pbuf [0:19];
  logic busy_seen;
  logic gv;
  logic [7:0] gd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_regdec dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_sop_i(sop), .pkt_eop_i(eop),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .rd_req_valid_i(rd_req), .rd_req_ready_o(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .pwm_update_o(pwm_up), .note_on_o(n_on), .note_off_o(n_off),
    .atk_coarse_o(c_coarse), .atk_fine_o(c_fine), .atk_prescale_o(c_presc),
    .pwm_duty_o(c_duty), .pwm_period_o(c_period), .pwm_div_o(c_div),
    .hold_coarse_o(c_hc), .hold_fine_o(c_hf), .flags_o(c_flags), .err_o(c_err)
  );

  always @(posedge clk) begin
    if (pwm_up) cnt_pwm++;
    if (n_on)   cnt_on++;
    if (n_off)  cnt_off++;
  end

  // {len, b0..b5, register checked, expected}; len 0 = check only
  localparam logic [71:0] VEC [NVEC] = '{
    {8'd4, 8'd0, 8'd10, 8'd200, 8'd7, 8'd0, 8'd0, 8'd12, 8'd200},          // R3 period
    {8'd0, 48'd0, 8'd13, 8'd7},                                            // R3 divider
    {8'd3, 8'd2, 8'd20, 8'd3, 8'd0, 8'd0, 8'd0, 8'd8, 8'd14},              // R4 clamp
    {8'd0, 48'd0, 8'd15, 8'd4},                                            // R4 R9 clamp error
    {8'd0, 48'd0, 8'd9, 8'd3},                                             // R4 fine
    {8'd2, 8'd2, 8'd6, 8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd6},                // R4 within limit
    {8'd3, 8'd7, 8'd1, 8'd2, 8'd0, 8'd0, 8'd0, 8'd17, 8'd1},               // R11 hold coarse
    {8'd2, 8'd7, 8'd9, 8'd0, 8'd0, 8'd0, 8'd0, 8'd18, 8'd2},               // R1 R11 short list
    {8'd5, 8'd5, 8'h0C, 8'd19, 8'hAA, 8'hBB, 8'd0, 8'd19, 8'hAA},          // R7 reg dest with address
    {8'd0, 48'd0, 8'd4, 8'd21},                                            // R7 R13 pointer past file
    {8'd6, 8'd5, 8'h0D, 8'd100, 8'd1, 8'd2, 8'd3, 8'd5, 8'd103},           // R7 table dest
    {8'd2, 8'd5, 8'h03, 8'd0, 8'd0, 8'd0, 8'd0, 8'd15, 8'd6},              // R8 R9 bad dest
    {8'd3, 8'd8, 8'h5A, 8'd9, 8'd0, 8'd0, 8'd0, 8'd19, 8'h5A},             // R11 flags
    {8'd3, 8'd9, 8'd1, 8'd2, 8'd0, 8'd0, 8'd0, 8'd19, 8'h5A},              // R12 unknown opcode
    {8'd3, 8'd5, 8'h04, 8'h11, 8'd0, 8'd0, 8'd0, 8'd4, 8'd22},             // R7 R13 pointer continues
    {8'd1, 8'd6, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd15, 8'd6}                // R8 store-table no effect
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send_buf(input int len);
    @(negedge clk); sop = 1;
    @(negedge clk); sop = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = pbuf[i];
      @(negedge clk);
    end
    in_valid = 0; eop = 1;
    @(negedge clk); eop = 0;
    busy_seen = !in_ready;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send6(input int len, input logic [47:0] v);
    for (int i = 0; i < 6; i++) pbuf[i] = v[47 - 8*i -: 8];
    send_buf(len);
  endtask

  task automatic read_byte(output logic v, output logic [7:0] d);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
    logic v;
    send6(3, {8'd4, 8'd0, idx, 24'd0});
    read_byte(v, d);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset values
    check("R10 coarse", c_coarse, 8'd5);
    check("R10 fine", c_fine, 8'd0);
    check("R10 prescale", c_presc, 8'd4);
    check("R10 duty", c_duty, 8'd127);
    check("R10 period", c_period, 8'd255);
    check("R10 div", c_div, 8'd5);
    check("R10 hold", {c_hc[3:0], 4'h0} | 8'(c_hf == 8'd250), 8'd1);
    check("R10 flags", c_flags, 8'd0);
    check("R10 err", c_err, 8'd0);
    check("R2 ready after reset", {7'd0, in_ready}, 8'd1);
    read_reg(8'd16, d);
    check("R10 max coarse", d, 8'd14);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][71:64] != 0) send6(int'(VEC[k][71:64]), VEC[k][63:16]);
      read_reg(VEC[k][15:8], d);
      check($sformatf("vector %0d (R1-R13 table)", k), d, VEC[k][7:0]);
    end

    check("R3 pwm pulses", 8'(cnt_pwm), 8'd1);
    check("R4 note-on pulses", 8'(cnt_on), 8'd2);
    send6(2, {8'd1, 8'd99, 32'd0});
    check("R4 velocity note-on", 8'(cnt_on), 8'd3);
    send6(1, {8'd3, 40'd0});
    check("R4 note-off", 8'(cnt_off), 8'd1);
    check("R2 busy after end strobe", {7'd0, busy_seen}, 8'd1);

    // R5 R6 table read with auto-increment
    send6(3, {8'd4, 8'd1, 8'd100, 24'd0});
    for (int i = 0; i < 3; i++) begin
      read_byte(gv, gd);
      check("R6 table read", gd, 8'(i + 1));
    end
    read_reg(8'd1, d);
    check("R5 R6 table pointer", d, 8'd103);

    // R6 register read auto-increment
    send6(3, {8'd4, 8'd0, 8'd11, 24'd0});
    read_byte(gv, gd);
    check("R6 reg read first", gd, 8'd10);
    read_byte(gv, gd);
    check("R6 reg read second", gd, 8'd200);

    // R13 read past file
    send6(3, {8'd4, 8'd0, 8'd25, 24'd0});
    read_byte(gv, gd);
    check("R13 read past file", {7'd0, gv}, 8'd1);
    check("R13 read value", gd, 8'd0);

    // R6 R9 invalid source
    send6(2, {8'd4, 8'd2, 32'd0});
    read_byte(gv, gd);
    check("R6 invalid source no response", {7'd0, gv}, 8'd0);
    check("R9 err after bad read", c_err, 8'd7);

    // R8 destination 6
    send6(4, {8'd5, 8'd6, 8'd1, 8'd2, 16'd0});
    read_reg(8'd6, d);
    check("R8 dest6 pointer", d, 8'd2);
    check("R8 dest6 no error", c_err, 8'd7);

    // R1 length limits
    pbuf[0] = 8'd8;
    for (int i = 1; i < 18; i++) pbuf[i] = 8'h33;
    send_buf(18);
    check("R1 17 args discarded", c_flags, 8'h5A);
    pbuf[1] = 8'h44;
    send_buf(17);
    check("R1 16 args executed", c_flags, 8'h44);
    send_buf(0);
    check("R1 empty packet no busy", {7'd0, busy_seen}, 8'd0);
    check("R1 empty packet no pulse", 8'(cnt_on + cnt_off + cnt_pwm), 8'd5);

    finish_up();
  end
endmodule